// File: doc/BRIEF.md
# Bi-phase Serial Word Encoder for a 1 Mbit/s Command/Response Bus

This block turns a 16-bit parallel word into one serial word of twenty bit times for a MIL-STD-1553 style bus and drives a complementary bi-phase output pair into a line transceiver. Each word has three parts: a three-bit-time sync field whose polarity marks it as a command/status word or a data word, the sixteen data bits sent most significant first, and one odd parity bit.

Software or a protocol engine pulses an active-low load strobe to place the next word in a holding register. It then holds the enable input high to send. While the enable stays high, words leave back to back with no gap. The holding register is free to take the next word as soon as the current word has started. The busy output covers the first sixteen bit times of each word. The moment busy falls is the decision point: the enable level and the sync choice sampled then decide whether a further word follows and what kind it is. An active-low clear aborts everything at once.

Top module: `manch_word_enc`

## Requirements
- R1: With no word in progress, `txPos` and `txNeg` are both 1. While a word is being sent they are always opposite, with `txNeg` the complement of `txPos`.
- R2: On every rising clock edge where `loadN` is 0, the holding register takes `dataIn`. A load made while a word is being sent does not alter that word.
- R3: If `encEnable` is 1 at a rising edge while the block is idle, a word starts on that edge. `txBusy` is then 1 for the first 16 bit times of the word and 0 for its last 4 bit times.
- R4: `encEnable` is sampled on the clock edge where `txBusy` falls. If it is 1, the next word starts right after the 20th bit time with no gap. If it is 0, the outputs return to idle after the 20th bit time.
- R5: The sync polarity of the first word is `syncSel` at its start edge. For each chained word it is `syncSel` on the busy-fall edge of the word before. With `syncSel`=1 (command/status), `txPos` is 1 for 1.5 bit times and then 0 for 1.5 bit times. With `syncSel`=0 (data), the order is reversed.
- R6: Bit times 4 to 19 carry the 16 data bits in order, from bit 15 down to bit 0. On `txPos`, a 1 is high in the first half of its bit cell and low in the second half; a 0 is low then high.
- R7: Bit time 20 carries odd parity over the 16 data bits: the parity bit is 1 exactly when the data holds an even number of ones. It uses the same cell coding as a data bit.
- R8: `pocN`=0 acts at once, without waiting for a clock. It ends any word in progress, drives both outputs to 1 and `txBusy` to 0, and clears the holding register to 0x0000.
- R9: Each half bit cell lasts `HALF_CLKS` clock cycles (default 6, which gives 1 Mbit/s from 12 MHz).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit-timing clock (12 MHz nominal) |
| pocN | input | 1 | Asynchronous active-low clear and abort |
| loadN | input | 1 | Active-low strobe that loads the holding register |
| dataIn | input | 16 | Parallel word to be sent |
| encEnable | input | 1 | Level enable; starts a word and chains further words |
| syncSel | input | 1 | 1 = command/status sync, 0 = data sync |
| txPos | output | 1 | True bi-phase output |
| txNeg | output | 1 | Complement bi-phase output |
| txBusy | output | 1 | High during the first 16 bit times of each word |

## Verification
The bench checks every half-bit of every word against a waveform it builds itself from the data, the sync choice and the parity. A misplaced half-bit counter, a wrong bit order or a parity of the wrong sense would show as a level mismatch at that exact point. Chaining is checked from both sides of the busy-fall sample point. Dropping the enable before busy falls must end transmission after one word. Dropping it just after busy falls must still send one more word. An encoder that sampled the enable at the end of the word would get one of these two cases wrong. A reload during a word and a sync change during a word must affect only the following word, so a design that copied the holding register or the sync select too late would corrupt the current word. The clear is applied mid-word and then followed by a word sent with no load, which exposes any holding register that survives the clear.

// File: rtl/manch_word_pkg.sv
package manch_word_pkg;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_SYNC_LEAD,
    PH_SYNC_TRAIL,
    PH_BIT_LEAD,
    PH_BIT_TRAIL,
    PH_PAR_LEAD,
    PH_PAR_TRAIL
  } phase_t;

  typedef struct packed {
    logic   startWord;   // copy holding register into shifter
    logic   firstWord;   // start from idle: take live sync select
    logic   sampleNext;  // busy-fall edge: capture sync for next word
    logic   shiftBit;    // end of a data bit cell
    phase_t phase;
  } enc_ctl_t;

endpackage

// File: rtl/manch_word_ctl.sv
module manch_word_ctl
  import manch_word_pkg::*;
#(
  parameter int HALF_CLKS = 6,
  parameter int DATA_W    = 16
) (
  input  logic     clk,
  input  logic     pocN,
  input  logic     encEnable,
  output enc_ctl_t ctl,
  output logic     txBusy
);

  localparam int SYNC_HALVES = 3;
  localparam int HEAD_HALVES = 2 * SYNC_HALVES;
  localparam int DATA_END    = HEAD_HALVES + 2 * DATA_W;
  localparam int WORD_HALVES = DATA_END + 2;
  localparam int BUSY_HALVES = 2 * DATA_W;
  localparam int HW          = $clog2(WORD_HALVES);
  localparam int SW          = (HALF_CLKS > 1) ? $clog2(HALF_CLKS) : 1;

  logic          active;
  logic          contNext;
  logic [HW-1:0] halfIdx;
  logic [SW-1:0] subCnt;
  logic          lastSub;
  logic          lastHalf;
  logic          busyEnd;

  assign lastSub  = (subCnt == SW'(HALF_CLKS - 1));
  assign lastHalf = (halfIdx == HW'(WORD_HALVES - 1));
  assign busyEnd  = active && lastSub && (halfIdx == HW'(BUSY_HALVES - 1));

  always_ff @(posedge clk or negedge pocN) begin
    if (!pocN) begin
      active   <= 1'b0;
      contNext <= 1'b0;
      halfIdx  <= '0;
      subCnt   <= '0;
    end else begin
      if (!active) begin
        if (encEnable) begin
          active  <= 1'b1;
          halfIdx <= '0;
          subCnt  <= '0;
        end
      end else if (lastSub) begin
        subCnt <= '0;
        if (lastHalf) begin
          halfIdx <= '0;
          active  <= contNext;
        end else begin
          halfIdx <= halfIdx + 1'b1;
        end
      end else begin
        subCnt <= subCnt + 1'b1;
      end
      if (busyEnd) contNext <= encEnable;
    end
  end

  always_comb begin
    ctl.startWord  = (!active && encEnable) ||
                     (active && lastSub && lastHalf && contNext);
    ctl.firstWord  = !active;
    ctl.sampleNext = busyEnd;
    ctl.shiftBit   = active && lastSub && halfIdx[0] &&
                     (halfIdx >= HW'(HEAD_HALVES)) && (halfIdx < HW'(DATA_END));
    if (!active)                            ctl.phase = PH_IDLE;
    else if (halfIdx < HW'(SYNC_HALVES))    ctl.phase = PH_SYNC_LEAD;
    else if (halfIdx < HW'(HEAD_HALVES))    ctl.phase = PH_SYNC_TRAIL;
    else if (halfIdx < HW'(DATA_END))       ctl.phase = halfIdx[0] ? PH_BIT_TRAIL : PH_BIT_LEAD;
    else                                    ctl.phase = halfIdx[0] ? PH_PAR_TRAIL : PH_PAR_LEAD;
  end

  assign txBusy = active && (halfIdx < HW'(BUSY_HALVES));

  // R9
  half_hold_chk: assert property (@(posedge clk) disable iff (!pocN)
    (active && !lastSub) |=> $stable(halfIdx));

  // R3
  busy_tail_chk: assert property (@(posedge clk) disable iff (!pocN)
    $fell(txBusy) |-> active);

  // R4
  stop_idle_chk: assert property (@(posedge clk) disable iff (!pocN)
    (active && lastSub && lastHalf && !contNext) |=> (!txBusy && ctl.phase == PH_IDLE));

  // R4
  chain_busy_chk: assert property (@(posedge clk) disable iff (!pocN)
    (active && lastSub && lastHalf && contNext) |=> txBusy);

endmodule

// File: rtl/manch_word_dp.sv
module manch_word_dp
  import manch_word_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              pocN,
  input  logic              loadN,
  input  logic [DATA_W-1:0] dataIn,
  input  logic              syncSel,
  input  enc_ctl_t          ctl,
  output logic              txPos,
  output logic              txNeg
);

  logic [DATA_W-1:0] holdReg;
  logic [DATA_W-1:0] shiftReg;
  logic              syncType;
  logic              pendSync;
  logic              parityBit;
  logic              level;

  always_ff @(posedge clk or negedge pocN) begin
    if (!pocN) begin
      holdReg   <= '0;
      shiftReg  <= '0;
      syncType  <= 1'b0;
      pendSync  <= 1'b0;
      parityBit <= 1'b0;
    end else begin
      if (!loadN) holdReg <= dataIn;
      if (ctl.sampleNext) pendSync <= syncSel;
      if (ctl.startWord) begin
        shiftReg  <= holdReg;
        syncType  <= ctl.firstWord ? syncSel : pendSync;
        parityBit <= ~^holdReg;
      end else if (ctl.shiftBit) begin
        shiftReg <= {shiftReg[DATA_W-2:0], 1'b0};
      end
    end
  end

  always_comb begin
    unique case (ctl.phase)
      PH_SYNC_LEAD:  level = syncType;
      PH_SYNC_TRAIL: level = ~syncType;
      PH_BIT_LEAD:   level = shiftReg[DATA_W-1];
      PH_BIT_TRAIL:  level = ~shiftReg[DATA_W-1];
      PH_PAR_LEAD:   level = parityBit;
      PH_PAR_TRAIL:  level = ~parityBit;
      default:       level = 1'b1;
    endcase
  end

  assign txPos = (ctl.phase == PH_IDLE) ? 1'b1 : level;
  assign txNeg = (ctl.phase == PH_IDLE) ? 1'b1 : ~level;

  // R1
  idle_pair_chk: assert property (@(posedge clk) disable iff (!pocN)
    (ctl.phase == PH_IDLE) |-> (txPos && txNeg));

  // R1
  complement_chk: assert property (@(posedge clk) disable iff (!pocN)
    (ctl.phase != PH_IDLE) |-> (txPos != txNeg));

  // R2
  hold_keep_chk: assert property (@(posedge clk) disable iff (!pocN)
    loadN |=> $stable(holdReg));

  // R6
  lead_trail_chk: assert property (@(posedge clk) disable iff (!pocN)
    (ctl.phase == PH_BIT_LEAD && ctl.shiftBit == 1'b0) |=>
      (ctl.phase == PH_BIT_LEAD || ctl.phase == PH_BIT_TRAIL));

endmodule

// File: rtl/manch_word_enc.sv
module manch_word_enc
  import manch_word_pkg::*;
#(
  parameter int HALF_CLKS = 6,
  parameter int DATA_W    = 16
) (
  input  logic              clk,
  input  logic              pocN,
  input  logic              loadN,
  input  logic [DATA_W-1:0] dataIn,
  input  logic              encEnable,
  input  logic              syncSel,
  output logic              txPos,
  output logic              txNeg,
  output logic              txBusy
);

  enc_ctl_t ctl;

  manch_word_ctl #(.HALF_CLKS(HALF_CLKS), .DATA_W(DATA_W)) uCtl (
    .clk       (clk),
    .pocN      (pocN),
    .encEnable (encEnable),
    .ctl       (ctl),
    .txBusy    (txBusy)
  );

  manch_word_dp #(.DATA_W(DATA_W)) uDp (
    .clk     (clk),
    .pocN    (pocN),
    .loadN   (loadN),
    .dataIn  (dataIn),
    .syncSel (syncSel),
    .ctl     (ctl),
    .txPos   (txPos),
    .txNeg   (txNeg)
  );

endmodule

// File: tb/manch_word_enc_test.sv
module manch_word_enc_test;

  localparam int HALF  = 6;
  localparam int WORDC = 40 * HALF;

  logic        clk = 1'b0;
  logic        pocN = 1'b0;
  logic        loadN = 1'b1;
  logic [15:0] dataIn = '0;
  logic        encEnable = 1'b0;
  logic        syncSel = 1'b0;
  logic        txPos, txNeg, txBusy;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;

  // {sync, data}
  localparam logic [16:0] VECS [5] = '{17'h1_A5C3, 17'h0_FFFF, 17'h1_0000,
                                       17'h0_8001, 17'h0_1234};

  manch_word_enc uut (
    .clk(clk), .pocN(pocN), .loadN(loadN), .dataIn(dataIn),
    .encEnable(encEnable), .syncSel(syncSel),
    .txPos(txPos), .txNeg(txNeg), .txBusy(txBusy)
  );

  always #2.5 clk = ~clk;

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      fails++;
      $display("FAIL watchdog expired actual=%0d expected<150000", cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic lvlOf(input logic [15:0] d, input logic s, input int h);
    logic p;
    logic b;
    p = ~^d;
    if (h < 3) return s;
    if (h < 6) return ~s;
    if (h < 38) begin
      b = d[15 - (h - 6) / 2];
      return (h % 2 == 0) ? b : ~b;
    end
    return (h == 38) ? p : ~p;
  endfunction

  // Checks one full word; optional stimulus during it.
  task automatic expectWord(input logic [15:0] d, input logic s,
                            input logic [15:0] nd, input logic ns, input bit doLoad,
                            input bit dropEarly, input bit dropLate, input string tag);
    int bad = 0;
    int badBusy = 0;
    logic [31:0] fAct = 0;
    logic [31:0] fExp = 0;
    for (int i = 0; i < WORDC; i++) begin
      int h;
      logic e;
      @(negedge clk);
      h = i / HALF;
      e = lvlOf(d, s, h);
      if (txPos !== e || txNeg !== ~e) begin
        if (bad == 0) begin
          fAct = {h[15:0], 14'd0, txPos, txNeg};
          fExp = {h[15:0], 14'd0, e, ~e};
        end
        bad++;
      end
      if (txBusy !== (h < 32)) badBusy++;
      if (loadN == 1'b0) loadN = 1'b1;
      if (doLoad && i == 4 * HALF) begin dataIn = nd; loadN = 1'b0; end
      if (i == 20 * HALF) begin syncSel = ns; if (dropEarly) encEnable = 1'b0; end
      if (dropLate && i == 33 * HALF) encEnable = 1'b0;
    end
    chk(bad == 0, tag, fAct, fExp);
    chk(badBusy == 0, {"R3 busy window ", tag}, badBusy, 0);
  endtask

  task automatic checkIdle(input string tag);
    chk(txPos === 1'b1 && txNeg === 1'b1 && txBusy === 1'b0, tag,
        {txPos, txNeg, txBusy}, 3'b110);
  endtask

  task automatic loadWord(input logic [15:0] d);
    @(negedge clk);
    dataIn = d;
    loadN  = 1'b0;
    @(negedge clk);
    loadN  = 1'b1;
  endtask

  initial begin
    // reset state (R1, R8)
    repeat (3) @(negedge clk);
    checkIdle("R8 outputs during clear");
    pocN = 1'b1;
    repeat (2) @(negedge clk);
    checkIdle("R1 idle after reset");

    // table of single words: R5 R6 R7 R9
    for (int v = 0; v < 5; v++) begin
      loadWord(VECS[v][15:0]);
      encEnable = 1'b1;
      syncSel   = VECS[v][16];
      @(posedge clk);
      expectWord(VECS[v][15:0], VECS[v][16], 16'h0, 1'b0, 1'b0, 1'b1, 1'b0,
                 "R5 R6 R7 R9 single word");
      @(negedge clk);
      checkIdle("R4 stop after single word");
    end

    // R4 chain with reload during word (R2) and sync change (R5)
    loadWord(16'h1357);
    encEnable = 1'b1;
    syncSel   = 1'b1;
    @(posedge clk);
    expectWord(16'h1357, 1'b1, 16'hC0DE, 1'b0, 1'b1, 1'b0, 1'b0, "R2 R4 chain word one");
    expectWord(16'hC0DE, 1'b0, 16'h0F0F, 1'b1, 1'b1, 1'b1, 1'b0, "R4 R5 chain word two");
    @(negedge clk);
    checkIdle("R4 stop after chain");

    // R4 late drop: enable falls just after busy falls, one more word goes out
    loadWord(16'h00FF);
    encEnable = 1'b1;
    syncSel   = 1'b0;
    @(posedge clk);
    expectWord(16'h00FF, 1'b0, 16'h7E81, 1'b1, 1'b1, 1'b0, 1'b1, "R4 late drop word one");
    expectWord(16'h7E81, 1'b1, 16'h0, 1'b1, 1'b0, 1'b0, 1'b0, "R4 late drop extra word");
    @(negedge clk);
    checkIdle("R4 stop after late drop");

    // R8 abort mid-word
    loadWord(16'hBEEF);
    encEnable = 1'b1;
    syncSel   = 1'b1;
    @(posedge clk);
    repeat (50) @(negedge clk);
    pocN = 1'b0;
    encEnable = 1'b0;
    #1;
    checkIdle("R8 abort mid word");
    @(negedge clk);
    pocN = 1'b1;
    @(negedge clk);
    checkIdle("R8 idle after abort");
    encEnable = 1'b1;
    syncSel   = 1'b0;
    @(posedge clk);
    expectWord(16'h0000, 1'b0, 16'h0, 1'b0, 1'b0, 1'b1, 1'b0, "R8 holding register cleared");
    @(negedge clk);
    checkIdle("R1 idle at end");

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule